// File: doc/BRIEF.md
# Word Shifter with Saturating Register Amounts

A purely combinational 32-bit shifter for a processor datapath. It moves an input word left or right by a selected number of positions, using one of four kinds of movement: logical left (zeros enter at the bottom), logical right (zeros enter at the top), arithmetic right (copies of the sign bit enter at the top) and rotate right (bits leaving the bottom re-enter at the top). Next to the shifted word it produces a carry-out that holds the last bit pushed out of the word.

The amount comes from one of two places. The first is a 5-bit field carried in the instruction, which covers 0 to 31. The second is the low byte of a register operand, which covers 0 to 255. Register amounts of 32 or more give fully saturated results: every bit has left the word for the logical kinds, the word is all sign for the arithmetic kind, and the rotation wraps modulo 32. An amount of zero leaves the word untouched and hands the incoming carry flag straight through.

Top module: `bsh_top`

## Requirements
- R1: With `shift_kind` = 2'b00 (logical left) and an amount n from 1 to 31, `data_out` is `data_in` shifted left by n with zeros entering at the bottom, which is `data_in` times 2^n modulo 2^32. `carry_out` is `data_in[32-n]`.
- R2: With `shift_kind` = 2'b01 (logical right) and n from 1 to 31, `data_out` is `data_in` shifted right by n with zeros entering at the top. `carry_out` is `data_in[n-1]`.
- R3: With `shift_kind` = 2'b10 (arithmetic right) and n from 1 to 31, `data_out` is `data_in` shifted right by n with copies of `data_in[31]` entering at the top. `carry_out` is `data_in[n-1]`.
- R4: With `shift_kind` = 2'b11 (rotate right), `data_out` is `data_in` rotated right by n modulo 32. For a nonzero n that is a multiple of 32, `data_out` equals `data_in` and `carry_out` is `data_in[31]`. For any other nonzero n, `carry_out` equals `data_out[31]`.
- R5: With `amt_from_reg` = 0, the amount is `amt_imm` (0 to 31) and `amt_reg_word` has no effect. With `amt_from_reg` = 1, the amount is `amt_reg_word[7:0]`, and bits 31:8 of that word have no effect.
- R6: With an amount of zero, of any kind and from either source, `data_out` equals `data_in` and `carry_out` equals `carry_in`.
- R7: For logical left and logical right with an amount of exactly 32, `data_out` is zero. The carry is `data_in[0]` for a left shift and `data_in[31]` for a right shift. With an amount above 32, both `data_out` and `carry_out` are zero.
- R8: For arithmetic right with an amount of 32 or more, every bit of `data_out` and `carry_out` equals `data_in[31]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_in | input | 32 | Word to be shifted |
| carry_in | input | 1 | Incoming carry flag, passed through for a zero amount |
| shift_kind | input | 2 | 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right |
| amt_from_reg | input | 1 | 1 takes the amount from the register operand, 0 from the immediate |
| amt_imm | input | 5 | Immediate shift amount |
| amt_reg_word | input | 32 | Register operand; only bits 7:0 are used as the amount |
| data_out | output | 32 | Shifted word |
| carry_out | output | 1 | Last bit shifted out, or `carry_in` for a zero amount |

## Verification
The bench concentrates on the amounts 0, 1, 31, 32, 33, 63, 64 and 255 under every kind, and on words whose sign bit and edge bits differ.

Each kind of mistake shows up differently at those amounts:
- A design that reduced every register amount modulo 32 would give a passthrough for a logical shift by 32 where zero is expected.
- A design that took the carry from the wrong end would report `data_in[n]` or the bit on the opposite side.
- A design that treated zero as a full shift would clear the word or lose `carry_in`.
- An arithmetic shift with a zero fill would lose the sign on negative words.
- A decoder that used more than the low byte of the register word would change results when garbage is placed in bits 31:8.

// File: rtl/bsh_pkg.sv
// Package: shared encodings for the word shifter.
// Assumes a two-bit kind code that the instruction decoder drives directly.
package bsh_pkg;

    // Kind of movement applied to the word; the codes are fixed by the decoder.
    typedef enum logic [1:0] {
        BSH_LSL = 2'd0,
        BSH_LSR = 2'd1,
        BSH_ASR = 2'd2,
        BSH_ROR = 2'd3
    } bsh_kind_e;

endpackage

// File: rtl/bsh_amount_sel.sv
// Module: bsh_amount_sel
// Picks the shift amount from either the immediate field or the low byte of
// the register operand, and classifies it: zero, exactly one word width,
// above one word width, and zero modulo the word width.
// Assumes WORD_W is a power of two and REG_AMT_W > log2(WORD_W).
module bsh_amount_sel #(
    parameter int WORD_W    = 32,
    parameter int IMM_W     = 5,
    parameter int REG_AMT_W = 8
) (
    input  logic                        amt_from_reg,
    input  logic [IMM_W-1:0]            amt_imm,
    input  logic [WORD_W-1:0]           amt_reg_word,
    output logic                        amt_zero,
    output logic                        amt_eq_w,
    output logic                        amt_gt_w,
    output logic                        low_zero,
    output logic [$clog2(WORD_W)-1:0]   amt_low
);
    localparam int LOG_W = $clog2(WORD_W);

    logic [REG_AMT_W-1:0] amt;
    logic                 unused_reg_hi;

    // Bits of the register word above the amount byte play no part.
    assign unused_reg_hi = ^amt_reg_word[WORD_W-1:REG_AMT_W];

    // Choose the source of the amount, widening the immediate.
    always_comb begin
        if (amt_from_reg) begin
            amt = amt_reg_word[REG_AMT_W-1:0];
        end else begin
            amt = REG_AMT_W'(amt_imm);
        end
    end

    // Classify the amount for the saturation and passthrough paths.
    always_comb begin
        amt_zero = (amt == '0);
        amt_eq_w = (amt == REG_AMT_W'(WORD_W));
        amt_gt_w = (amt >  REG_AMT_W'(WORD_W));
        amt_low  = amt[LOG_W-1:0];
        low_zero = (amt[LOG_W-1:0] == '0);
    end

    // Check that an immediate amount never reaches the saturating range (R5).
    always_comb begin
        if (!amt_from_reg) begin
            p_imm_no_sat_r5: assert (!amt_eq_w && !amt_gt_w)
                else $error("immediate amount classified as saturating");
        end
    end

endmodule

// File: rtl/bsh_log_shifter.sv
// Module: bsh_log_shifter
// Logarithmic shift network. Stage k moves the word by 2^k positions when bit
// k of the amount is set, using the fill that the selected kind requires.
// Covers amounts 0 to WORD_W-1 only; saturation is handled downstream.
// Assumes WORD_W is a power of two.
module bsh_log_shifter
    import bsh_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0]           data_in,
    input  bsh_kind_e                   kind,
    input  logic [$clog2(WORD_W)-1:0]   amt_low,
    output logic [WORD_W-1:0]           shifted
);
    localparam int LOG_W = $clog2(WORD_W);

    logic [WORD_W-1:0] stage [0:LOG_W];
    logic              sign_bit;

    assign sign_bit = data_in[WORD_W-1];
    assign stage[0] = data_in;

    for (genvar k = 0; k < LOG_W; k++) begin : g_stage
        localparam int S = 1 << k;
        logic [WORD_W-1:0] moved;

        // Move this stage's input by 2^k with the fill for the kind.
        always_comb begin
            unique case (kind)
                BSH_LSL: moved = {stage[k][WORD_W-1-S:0], {S{1'b0}}};
                BSH_LSR: moved = {{S{1'b0}}, stage[k][WORD_W-1:S]};
                BSH_ASR: moved = {{S{sign_bit}}, stage[k][WORD_W-1:S]};
                BSH_ROR: moved = {stage[k][S-1:0], stage[k][WORD_W-1:S]};
                default: moved = stage[k];
            endcase
        end

        // Apply the stage only when its amount bit is set.
        assign stage[k+1] = amt_low[k] ? moved : stage[k];
    end

    assign shifted = stage[LOG_W];

    // After a left shift, no bit below the amount may be set (R1).
    always_comb begin
        if (kind == BSH_LSL) begin
            p_lsl_low_clear_r1: assert ((shifted & ~({WORD_W{1'b1}} << amt_low)) == '0)
                else $error("left shift left bits set below the amount");
        end
    end

endmodule

// File: rtl/bsh_edge_fix.sv
// Module: bsh_edge_fix
// Produces the final word and carry. It handles the zero amount
// (passthrough), full-width and larger amounts (saturation) and the rotate
// wrap, and picks the last bit shifted out as the carry.
// Assumes shifted comes from bsh_log_shifter with the same kind and amt_low.
module bsh_edge_fix
    import bsh_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0]           data_in,
    input  logic                        carry_in,
    input  bsh_kind_e                   kind,
    input  logic                        amt_zero,
    input  logic                        amt_eq_w,
    input  logic                        amt_gt_w,
    input  logic                        low_zero,
    input  logic [$clog2(WORD_W)-1:0]   amt_low,
    input  logic [WORD_W-1:0]           shifted,
    output logic [WORD_W-1:0]           data_out,
    output logic                        carry_out
);
    localparam int LOG_W = $clog2(WORD_W);

    logic [LOG_W:0]   left_idx_w;
    logic [LOG_W-1:0] left_idx;
    logic [LOG_W-1:0] right_idx;
    logic             sign_bit;
    logic             left_bit;
    logic             right_bit;

    // Positions of the last bit leaving the word for an in-range amount.
    always_comb begin
        left_idx_w = (LOG_W+1)'(WORD_W) - {1'b0, amt_low};
        left_idx   = left_idx_w[LOG_W-1:0];
        right_idx  = amt_low - 1'b1;
        sign_bit   = data_in[WORD_W-1];
        left_bit   = data_in[left_idx];
        right_bit  = data_in[right_idx];
    end

    // Select the word and carry for each kind and amount range.
    always_comb begin
        data_out  = shifted;
        carry_out = carry_in;
        if (amt_zero) begin
            data_out  = data_in;
            carry_out = carry_in;
        end else begin
            unique case (kind)
                BSH_LSL: begin
                    if (amt_gt_w) begin
                        data_out  = '0;
                        carry_out = 1'b0;
                    end else if (amt_eq_w) begin
                        data_out  = '0;
                        carry_out = data_in[0];
                    end else begin
                        carry_out = left_bit;
                    end
                end
                BSH_LSR: begin
                    if (amt_gt_w) begin
                        data_out  = '0;
                        carry_out = 1'b0;
                    end else if (amt_eq_w) begin
                        data_out  = '0;
                        carry_out = sign_bit;
                    end else begin
                        carry_out = right_bit;
                    end
                end
                BSH_ASR: begin
                    if (amt_gt_w || amt_eq_w) begin
                        data_out  = {WORD_W{sign_bit}};
                        carry_out = sign_bit;
                    end else begin
                        carry_out = right_bit;
                    end
                end
                BSH_ROR: begin
                    if (low_zero) begin
                        data_out  = data_in;
                        carry_out = sign_bit;
                    end else begin
                        carry_out = shifted[WORD_W-1];
                    end
                end
                default: begin
                    data_out  = shifted;
                    carry_out = carry_in;
                end
            endcase
        end
    end

    // A rotation keeps the number of set bits (R4).
    always_comb begin
        if (kind == BSH_ROR) begin
            p_rot_keeps_ones_r4: assert ($countones(data_out) == $countones(data_in))
                else $error("rotate changed the population count");
        end
    end

    // Logical shifts past one word clear both the word and the carry (R7).
    always_comb begin
        if ((kind == BSH_LSL || kind == BSH_LSR) && amt_gt_w && !amt_zero) begin
            p_sat_clear_r7: assert (data_out == '0 && carry_out == 1'b0)
                else $error("logical shift beyond word width not cleared");
        end
    end

    // Arithmetic shifts of a full word or more leave only sign copies (R8).
    always_comb begin
        if (kind == BSH_ASR && (amt_gt_w || amt_eq_w)) begin
            p_asr_all_sign_r8: assert ((data_out == {WORD_W{data_in[WORD_W-1]}})
                                       && carry_out == data_in[WORD_W-1])
                else $error("arithmetic saturation lost the sign");
        end
    end

endmodule

// File: rtl/bsh_top.sv
// Module: bsh_top
// Combinational word shifter: amount selection, a logarithmic shift network
// and the saturation/carry stage. It holds no state and uses no clock.
// Assumes the kind code and the source select are stable while it is used.
module bsh_top
    import bsh_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int IMM_W     = 5,
    parameter int REG_AMT_W = 8
) (
    input  logic [WORD_W-1:0] data_in,
    input  logic              carry_in,
    input  logic [1:0]        shift_kind,
    input  logic              amt_from_reg,
    input  logic [IMM_W-1:0]  amt_imm,
    input  logic [WORD_W-1:0] amt_reg_word,
    output logic [WORD_W-1:0] data_out,
    output logic              carry_out
);
    localparam int LOG_W = $clog2(WORD_W);

    bsh_kind_e         kind;
    logic              amt_zero;
    logic              amt_eq_w;
    logic              amt_gt_w;
    logic              low_zero;
    logic [LOG_W-1:0]  amt_low;
    logic [WORD_W-1:0] shifted;

    // Interpret the kind code from the decoder.
    assign kind = bsh_kind_e'(shift_kind);

    bsh_amount_sel #(
        .WORD_W    (WORD_W),
        .IMM_W     (IMM_W),
        .REG_AMT_W (REG_AMT_W)
    ) u_amount (
        .amt_from_reg (amt_from_reg),
        .amt_imm      (amt_imm),
        .amt_reg_word (amt_reg_word),
        .amt_zero     (amt_zero),
        .amt_eq_w     (amt_eq_w),
        .amt_gt_w     (amt_gt_w),
        .low_zero     (low_zero),
        .amt_low      (amt_low)
    );

    bsh_log_shifter #(
        .WORD_W (WORD_W)
    ) u_network (
        .data_in (data_in),
        .kind    (kind),
        .amt_low (amt_low),
        .shifted (shifted)
    );

    bsh_edge_fix #(
        .WORD_W (WORD_W)
    ) u_edge (
        .data_in   (data_in),
        .carry_in  (carry_in),
        .kind      (kind),
        .amt_zero  (amt_zero),
        .amt_eq_w  (amt_eq_w),
        .amt_gt_w  (amt_gt_w),
        .low_zero  (low_zero),
        .amt_low   (amt_low),
        .shifted   (shifted),
        .data_out  (data_out),
        .carry_out (carry_out)
    );

    // A zero amount passes the word and the carry flag through (R6).
    always_comb begin
        if (amt_zero) begin
            p_zero_pass_r6: assert (data_out == data_in && carry_out == carry_in)
                else $error("zero amount altered the word or carry");
        end
    end

    // A right arithmetic shift never changes the sign bit (R3).
    always_comb begin
        if (kind == BSH_ASR) begin
            p_asr_sign_kept_r3: assert (data_out[WORD_W-1] == data_in[WORD_W-1])
                else $error("arithmetic shift changed the sign");
        end
    end

endmodule

// File: tb/tb_bsh_top.sv
// Bench for bsh_top: directed corner cases plus seeded random vectors,
// compared against a bit-by-bit reference model written in the bench.
module tb_bsh_top;

    logic        clk;
    logic        rst_n;
    logic [31:0] data_in;
    logic        carry_in;
    logic [1:0]  shift_kind;
    logic        amt_from_reg;
    logic [4:0]  amt_imm;
    logic [31:0] amt_reg_word;
    logic [31:0] data_out;
    logic        carry_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    bsh_top dut (
        .data_in      (data_in),
        .carry_in     (carry_in),
        .shift_kind   (shift_kind),
        .amt_from_reg (amt_from_reg),
        .amt_imm      (amt_imm),
        .amt_reg_word (amt_reg_word),
        .data_out     (data_out),
        .carry_out    (carry_out)
    );

    // 50 MHz clock: 20 ns period.
    initial clk = 1'b0;
    always #10 clk = ~clk;

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            errors = errors + 1;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Reference: apply n single-bit steps, tracking the bit that falls out.
    function automatic logic [32:0] model(input logic [31:0] x, input logic c,
                                          input logic [1:0] k, input int n);
        logic [31:0] w = x;
        logic        cy = c;
        for (int i = 0; i < n; i++) begin
            case (k)
                2'b00: begin cy = w[31]; w = {w[30:0], 1'b0}; end
                2'b01: begin cy = w[0];  w = {1'b0, w[31:1]}; end
                2'b10: begin cy = w[0];  w = {w[31], w[31:1]}; end
                default: begin cy = w[0]; w = {w[0], w[31:1]}; end
            endcase
        end
        return {cy, w};
    endfunction

    // Requirement that a given kind and amount exercises.
    function automatic string tag_of(input logic [1:0] k, input int n);
        if (n == 0) return "R6";
        if (k == 2'b11) return "R4";
        if (n >= 32 && k == 2'b10) return "R8";
        if (n >= 32) return "R7";
        case (k)
            2'b00: return "R1";
            2'b01: return "R2";
            default: return "R3";
        endcase
    endfunction

    // Drive one vector, let it settle away from the edge, compare to the model.
    task automatic run_vec(input string req, input logic [31:0] x, input logic c,
                           input logic [1:0] k, input logic from_reg,
                           input logic [4:0] imm, input logic [31:0] rw);
        int          n;
        logic [32:0] exp;
        @(posedge clk);
        #2;
        data_in      = x;
        carry_in     = c;
        shift_kind   = k;
        amt_from_reg = from_reg;
        amt_imm      = imm;
        amt_reg_word = rw;
        n   = from_reg ? int'(rw[7:0]) : int'(imm);
        exp = model(x, c, k, n);
        @(negedge clk);
        checks = checks + 1;
        if (data_out !== exp[31:0] || carry_out !== exp[32]) begin
            errors = errors + 1;
            $display("FAIL %s kind=%0d n=%0d in=%h: got %h/%b expected %h/%b",
                     req, k, n, x, data_out, carry_out, exp[31:0], exp[32]);
        end
    endtask

    initial begin
        int amts [8] = '{0, 1, 31, 32, 33, 63, 64, 255};
        logic [31:0] words [4] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hF234_012F, 32'h0000_0005};
        rst_n        = 1'b0;
        data_in      = '0;
        carry_in     = 1'b0;
        shift_kind   = 2'b00;
        amt_from_reg = 1'b0;
        amt_imm      = '0;
        amt_reg_word = '0;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Reset-state vector: all-zero inputs give zero outputs (R6).
        @(negedge clk);
        checks = checks + 1;
        if (data_out !== 32'h0 || carry_out !== 1'b0) begin
            errors = errors + 1;
            $display("FAIL R6 idle: got %h/%b expected 00000000/0", data_out, carry_out);
        end

        // R1: a left shift by 3 multiplies by 8.
        run_vec("R1", 32'd5, 1'b0, 2'b00, 1'b0, 5'd3, 32'h0);

        // R6: zero amount keeps carry_in set, for each kind and source.
        for (int k = 0; k < 4; k++) begin
            run_vec("R6", 32'hDEAD_BEEF, 1'b1, 2'(k), 1'b0, 5'd0, 32'hFFFF_FF00);
            run_vec("R6", 32'h1234_5678, 1'b1, 2'(k), 1'b1, 5'd7, 32'hABCD_EF00);
        end

        // R5: the unused source and the upper register bits have no effect.
        run_vec("R5", 32'h8000_0001, 1'b0, 2'b01, 1'b0, 5'd3, 32'hFFFF_FFC8);
        run_vec("R5", 32'h8000_0001, 1'b0, 2'b01, 1'b1, 5'd31, 32'hA5A5_A504);
        run_vec("R5", 32'hC000_0000, 1'b0, 2'b10, 1'b1, 5'd0, 32'h7700_0021);

        // Register amount sweep at the edge amounts, every kind (R1-R4, R7, R8).
        for (int k = 0; k < 4; k++) begin
            for (int a = 0; a < 8; a++) begin
                for (int w = 0; w < 4; w++) begin
                    run_vec(tag_of(2'(k), amts[a]), words[w], 1'b1, 2'(k), 1'b1, 5'd0,
                            {24'h5A5A5A, 8'(amts[a])});
                end
            end
        end

        // Seeded random vectors mixing both sources and all kinds.
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] x  = $urandom;
            logic [31:0] rw = $urandom;
            logic [1:0]  k  = 2'($urandom_range(0, 3));
            logic        fr = 1'($urandom_range(0, 1));
            logic [4:0]  im = 5'($urandom_range(0, 31));
            if ($urandom_range(0, 3) == 0) rw[7:0] = 8'($urandom_range(28, 36));
            run_vec(tag_of(k, fr ? int'(rw[7:0]) : int'(im)), x, 1'($urandom_range(0, 1)),
                    k, fr, im, rw);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule